// File: doc/BRIEF.md
# Dual-Access Banked Data Memory Arbiter

This block sits between two independent load/store ports of a processor core and a data memory built from several small single-ported banks. Consecutive word addresses are spread across the banks, so the low word-address bits select a bank and the remaining bits select the word inside it. Both ports may present a request in the same cycle. When the two requests land in different banks, both banks are driven in that cycle and the instruction completes without delay.

When both requests land in the same bank, the block detects the collision at run time. It serves port A in the current cycle and raises `stall` for that one cycle, so the core holds its pipeline. In the following cycle it serves port B from a captured copy of its request. The block ignores its request inputs during that second cycle. Read results for both ports come back together, one cycle after the last bank access of the instruction. The banks are synchronous memories with a one-cycle read latency and sit outside the block.

The core may therefore place two memory operations in one instruction even when they occasionally hit the same bank. Correctness never depends on the compiler proving that the two addresses are in different banks.

Top module: `dmem_pair_arb`

## Requirements
- R1: A request's bank is word-address bits [1:0] and its in-bank index is bits [ADDR_W-1:2]. A served request drives only its bank's enable, with that index on the bank's slice of `bank_idx`.
- R2: When both ports are valid and target different banks, both banks are enabled in the same cycle and `stall` stays low.
- R3: When both ports are valid and target the same bank, `stall` is high in that cycle and low in the next. Port A's bank access happens in the first cycle and port B's in the second.
- R4: A conflicting pair behaves as A followed by B. A read by A of the address B writes returns the old word. A read by B of the address A writes returns A's write data.
- R5: When both ports write the same address in one instruction, the word left in memory is port B's write data.
- R6: Read data for both ports is presented together, with `a_rvalid`/`b_rvalid`, in the cycle after the instruction's last bank access. No read-valid is raised in the stalled cycle's successor, while port B is still being served.
- R7: A read-valid pulses for exactly one cycle, and only for a port that issued a valid read. Writes and idle ports give no read-valid.
- R8: Request inputs presented during the second cycle of a conflict are ignored and cause no bank access of their own.
- R9: When only one port is valid, `stall` stays low and the request completes in one cycle.
- R10: After reset, with no request, `stall`, both read-valids and all bank enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Port A request present |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| b_valid | input | 1 | Port B request present |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| stall | output | 1 | Hold the pipeline one extra cycle (same-bank collision) |
| a_rvalid | output | 1 | Port A read data valid |
| a_rdata | output | DATA_W | Port A read data |
| b_rvalid | output | 1 | Port B read data valid |
| b_rdata | output | DATA_W | Port B read data |
| bank_en | output | NUM_BANKS | Per-bank access enable |
| bank_we | output | NUM_BANKS | Per-bank write enable |
| bank_idx | output | NUM_BANKS*(ADDR_W-log2 NUM_BANKS) | Per-bank word index, bank 0 in the low slice |
| bank_wdata | output | NUM_BANKS*DATA_W | Per-bank write data, bank 0 in the low slice |
| bank_rdata | input | NUM_BANKS*DATA_W | Per-bank read data, one cycle after access |

## Verification
The hardest situation to reach is the conflict's second cycle. There the block must act on its captured copy of port B while fresh, different request values sit on the ports. It must also keep port A's read word, which the bank returned a cycle early, until B's word arrives. The bench sweeps every bank pair and every read/write mix over four banks. In the second cycle of chosen conflicts it drives unrelated valid writes onto both ports, then reads those addresses back to show they were never written. Same-address pairs in each read/write order expose the A-then-B ordering.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  typedef enum logic {
    PH_ISSUE  = 1'b0,
    PH_SECOND = 1'b1
  } phase_e;
endpackage

// File: rtl/dmarb_bank_map.sv
module dmarb_bank_map #(
  parameter int ADDR_W = 8,
  parameter int BSEL_W = 2,
  parameter int IDX_W  = ADDR_W - BSEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BSEL_W-1:0] bank,
  output logic [IDX_W-1:0]  idx
);
  // Interleaving: low word-address bits pick the bank.
  assign bank = addr[BSEL_W-1:0];
  assign idx  = addr[ADDR_W-1:BSEL_W];
endmodule

// File: rtl/dmarb_seq.sv
module dmarb_seq
  import dmarb_pkg::*;
#(
  parameter int BSEL_W = 2,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic              a_we,
  input  logic [BSEL_W-1:0] a_bank,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              b_valid,
  input  logic              b_we,
  input  logic [BSEL_W-1:0] b_bank,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_wdata,
  output logic              stall,
  output phase_e            phase,
  output logic              slot0_v,
  output logic              slot0_we,
  output logic [BSEL_W-1:0] slot0_bank,
  output logic [IDX_W-1:0]  slot0_idx,
  output logic [DATA_W-1:0] slot0_wdata,
  output logic              slot1_v,
  output logic              slot1_we,
  output logic [BSEL_W-1:0] slot1_bank,
  output logic [IDX_W-1:0]  slot1_idx,
  output logic [DATA_W-1:0] slot1_wdata
);
  phase_e            phase_q, phase_d;
  logic              conflict;
  logic              hold_en;
  logic              hold_we_q;
  logic [BSEL_W-1:0] hold_bank_q;
  logic [IDX_W-1:0]  hold_idx_q;
  logic [DATA_W-1:0] hold_wdata_q;

  // Next-state logic
  always_comb begin
    conflict = (phase_q == PH_ISSUE) && a_valid && b_valid && (a_bank == b_bank);
    phase_d  = conflict ? PH_SECOND : PH_ISSUE;
    hold_en  = conflict;
  end

  // Slot selection: slot0 carries A, slot1 carries B (live or held)
  always_comb begin
    slot0_v     = (phase_q == PH_ISSUE) && a_valid;
    slot0_we    = a_we;
    slot0_bank  = a_bank;
    slot0_idx   = a_idx;
    slot0_wdata = a_wdata;
    if (phase_q == PH_SECOND) begin
      slot1_v     = 1'b1;
      slot1_we    = hold_we_q;
      slot1_bank  = hold_bank_q;
      slot1_idx   = hold_idx_q;
      slot1_wdata = hold_wdata_q;
    end else begin
      slot1_v     = b_valid && !conflict;
      slot1_we    = b_we;
      slot1_bank  = b_bank;
      slot1_idx   = b_idx;
      slot1_wdata = b_wdata;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_ISSUE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_we_q    <= b_we;
      hold_bank_q  <= b_bank;
      hold_idx_q   <= b_idx;
      hold_wdata_q <= b_wdata;
    end
  end

  assign stall = conflict;
  assign phase = phase_q;

  p_stall_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  p_b_served_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (slot1_v && !slot0_v));
  p_single_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ISSUE) && (a_valid != b_valid)) |-> !stall);
endmodule

// File: rtl/dmarb_bank_drive.sv
module dmarb_bank_drive #(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2,
  parameter int IDX_W     = 6,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot0_v,
  input  logic                        slot0_we,
  input  logic [BSEL_W-1:0]           slot0_bank,
  input  logic [IDX_W-1:0]            slot0_idx,
  input  logic [DATA_W-1:0]           slot0_wdata,
  input  logic                        slot1_v,
  input  logic                        slot1_we,
  input  logic [BSEL_W-1:0]           slot1_bank,
  input  logic [IDX_W-1:0]            slot1_idx,
  input  logic [DATA_W-1:0]           slot1_wdata,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS*IDX_W-1:0]  bank_idx,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel0, sel1;
    always_comb begin
      sel0 = slot0_v && (slot0_bank == BSEL_W'(g));
      sel1 = slot1_v && (slot1_bank == BSEL_W'(g));
      bank_en[g] = sel0 || sel1;
      if (sel0) begin
        bank_we[g]                       = slot0_we;
        bank_idx[g*IDX_W +: IDX_W]       = slot0_idx;
        bank_wdata[g*DATA_W +: DATA_W]   = slot0_wdata;
      end else begin
        bank_we[g]                       = sel1 && slot1_we;
        bank_idx[g*IDX_W +: IDX_W]       = slot1_idx;
        bank_wdata[g*DATA_W +: DATA_W]   = slot1_wdata;
      end
    end
  end

  p_no_bank_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0_v && slot1_v) |-> (slot0_bank != slot1_bank));
  p_en_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_en) == (32'(slot0_v) + 32'(slot1_v)));
endmodule

// File: rtl/dmarb_rd_return.sv
module dmarb_rd_return
  import dmarb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = 2,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  phase_e                      phase,
  input  logic                        conflict,
  input  logic                        slot0_v,
  input  logic                        slot0_we,
  input  logic [BSEL_W-1:0]           slot0_bank,
  input  logic                        slot1_v,
  input  logic                        slot1_we,
  input  logic [BSEL_W-1:0]           slot1_bank,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        a_rvalid,
  output logic [DATA_W-1:0]           a_rdata,
  output logic                        b_rvalid,
  output logic [DATA_W-1:0]           b_rdata
);
  logic              s1_a_rd_q, s1_a_rd_d;
  logic [BSEL_W-1:0] s1_a_bank_q, s1_a_bank_d;
  logic              s1_b_rd_q, s1_b_rd_d;
  logic [BSEL_W-1:0] s1_b_bank_q, s1_b_bank_d;
  logic              s1_hold_q, s1_hold_d;
  logic              s1_from2_q, s1_from2_d;
  logic              keep_en;
  logic              keep_rd_q;
  logic [DATA_W-1:0] keep_data_q;
  logic [DATA_W-1:0] a_word, b_word;

  assign a_word = bank_rdata[s1_a_bank_q*DATA_W +: DATA_W];
  assign b_word = bank_rdata[s1_b_bank_q*DATA_W +: DATA_W];

  // Next-state logic
  always_comb begin
    s1_a_rd_d   = slot0_v && !slot0_we;
    s1_a_bank_d = slot0_bank;
    s1_b_rd_d   = slot1_v && !slot1_we;
    s1_b_bank_d = slot1_bank;
    s1_hold_d   = conflict;
    s1_from2_d  = (phase == PH_SECOND);
    keep_en     = (phase == PH_SECOND);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_a_rd_q   <= 1'b0;
      s1_a_bank_q <= '0;
      s1_b_rd_q   <= 1'b0;
      s1_b_bank_q <= '0;
      s1_hold_q   <= 1'b0;
      s1_from2_q  <= 1'b0;
      keep_rd_q   <= 1'b0;
    end else begin
      s1_a_rd_q   <= s1_a_rd_d;
      s1_a_bank_q <= s1_a_bank_d;
      s1_b_rd_q   <= s1_b_rd_d;
      s1_b_bank_q <= s1_b_bank_d;
      s1_hold_q   <= s1_hold_d;
      s1_from2_q  <= s1_from2_d;
      if (keep_en) keep_rd_q <= s1_a_rd_q;
    end
  end

  // Port A's word arrives a cycle early on a conflict: park it.
  always_ff @(posedge clk) begin
    if (keep_en) keep_data_q <= a_word;
  end

  // Output stage
  always_comb begin
    a_rvalid = !s1_hold_q && (s1_from2_q ? keep_rd_q : s1_a_rd_q);
    b_rvalid = !s1_hold_q && s1_b_rd_q;
    a_rdata  = '0;
    b_rdata  = '0;
    if (a_rvalid) a_rdata = s1_from2_q ? keep_data_q : a_word;
    if (b_rvalid) b_rdata = b_word;
  end

  p_b_rvalid_from_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    b_rvalid |-> $past(slot1_v && !slot1_we));
endmodule

// File: rtl/dmem_pair_arb.sv
module dmem_pair_arb
  import dmarb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter int BSEL_W    = $clog2(NUM_BANKS),
  parameter int IDX_W     = ADDR_W - BSEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        a_valid,
  input  logic                        a_we,
  input  logic [ADDR_W-1:0]           a_addr,
  input  logic [DATA_W-1:0]           a_wdata,
  input  logic                        b_valid,
  input  logic                        b_we,
  input  logic [ADDR_W-1:0]           b_addr,
  input  logic [DATA_W-1:0]           b_wdata,
  output logic                        stall,
  output logic                        a_rvalid,
  output logic [DATA_W-1:0]           a_rdata,
  output logic                        b_rvalid,
  output logic [DATA_W-1:0]           b_rdata,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS*IDX_W-1:0]  bank_idx,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [BSEL_W-1:0] a_bank, b_bank;
  logic [IDX_W-1:0]  a_idx, b_idx;
  phase_e            phase;
  logic              s0_v, s0_we, s1_v, s1_we;
  logic [BSEL_W-1:0] s0_bank, s1_bank;
  logic [IDX_W-1:0]  s0_idx, s1_idx;
  logic [DATA_W-1:0] s0_wdata, s1_wdata;

  dmarb_bank_map #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W), .IDX_W(IDX_W)) u_map_a (
    .addr(a_addr), .bank(a_bank), .idx(a_idx));
  dmarb_bank_map #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W), .IDX_W(IDX_W)) u_map_b (
    .addr(b_addr), .bank(b_bank), .idx(b_idx));

  dmarb_seq #(.BSEL_W(BSEL_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_q),
    .a_valid(a_valid), .a_we(a_we), .a_bank(a_bank), .a_idx(a_idx), .a_wdata(a_wdata),
    .b_valid(b_valid), .b_we(b_we), .b_bank(b_bank), .b_idx(b_idx), .b_wdata(b_wdata),
    .stall(stall), .phase(phase),
    .slot0_v(s0_v), .slot0_we(s0_we), .slot0_bank(s0_bank), .slot0_idx(s0_idx),
    .slot0_wdata(s0_wdata),
    .slot1_v(s1_v), .slot1_we(s1_we), .slot1_bank(s1_bank), .slot1_idx(s1_idx),
    .slot1_wdata(s1_wdata));

  dmarb_bank_drive #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W), .IDX_W(IDX_W),
                     .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_sync_q),
    .slot0_v(s0_v), .slot0_we(s0_we), .slot0_bank(s0_bank), .slot0_idx(s0_idx),
    .slot0_wdata(s0_wdata),
    .slot1_v(s1_v), .slot1_we(s1_we), .slot1_bank(s1_bank), .slot1_idx(s1_idx),
    .slot1_wdata(s1_wdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_idx(bank_idx), .bank_wdata(bank_wdata));

  dmarb_rd_return #(.NUM_BANKS(NUM_BANKS), .BSEL_W(BSEL_W), .DATA_W(DATA_W)) u_ret (
    .clk(clk), .rst_n(rst_sync_q), .phase(phase), .conflict(stall),
    .slot0_v(s0_v), .slot0_we(s0_we), .slot0_bank(s0_bank),
    .slot1_v(s1_v), .slot1_we(s1_we), .slot1_bank(s1_bank),
    .bank_rdata(bank_rdata),
    .a_rvalid(a_rvalid), .a_rdata(a_rdata), .b_rvalid(b_rvalid), .b_rdata(b_rdata));

  p_quiet_after_stall_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stall |=> (!a_rvalid && !b_rvalid));
  p_rvalid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (a_rvalid && !a_valid && !b_valid) |=> !a_rvalid);
endmodule

// File: tb/tb_dmem_pair_arb.sv
module tb_dmem_pair_arb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = 4;
  localparam int IW = 6;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, a_we, b_valid, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic stall, a_rvalid, b_rvalid;
  logic [DW-1:0] a_rdata, b_rdata;
  logic [NB-1:0] bank_en, bank_we;
  logic [NB*IW-1:0] bank_idx;
  logic [NB*DW-1:0] bank_wdata, bank_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dmem_pair_arb #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_valid(b_valid), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .stall(stall), .a_rvalid(a_rvalid), .a_rdata(a_rdata),
    .b_rvalid(b_rvalid), .b_rdata(b_rdata),
    .bank_en(bank_en), .bank_we(bank_we), .bank_idx(bank_idx),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata));

  // Bank models: synchronous, one-cycle read latency
  logic [DW-1:0] mem [NB][DEPTH];
  logic [DW-1:0] brd [NB];
  logic [DW-1:0] ref_mem [NB*DEPTH];

  always @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (bank_en[b]) begin
        if (bank_we[b]) mem[b][bank_idx[b*IW +: IW]] <= bank_wdata[b*DW +: DW];
        else            brd[b] <= mem[b][bank_idx[b*IW +: IW]];
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_rd
    assign bank_rdata[g*DW +: DW] = brd[g];
  end

  function automatic logic [DW-1:0] init_word(input int addr);
    return DW'(addr * 37 + 3);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    a_valid = 1'b0; a_we = 1'b0; a_addr = '0; a_wdata = '0;
    b_valid = 1'b0; b_we = 1'b0; b_addr = '0; b_wdata = '0;
  endtask

  // One instruction; junk=1 drives unrelated writes in the second conflict cycle.
  task automatic run_op(input logic av, input logic awe, input logic [AW-1:0] aa,
                        input logic [DW-1:0] awd, input logic bv, input logic bwe,
                        input logic [AW-1:0] ba, input logic [DW-1:0] bwd,
                        input bit junk);
    logic conf;
    logic [NB-1:0] en0, en1;
    logic [DW-1:0] ea, eb;
    logic era, erb;
    conf = av && bv && (aa[1:0] == ba[1:0]);
    en0 = av ? (NB'(1) << aa[1:0]) : '0;
    en1 = bv ? (NB'(1) << ba[1:0]) : '0;
    era = av && !awe;
    erb = bv && !bwe;
    ea = era ? ref_mem[aa] : '0;
    if (av && awe) ref_mem[aa] = awd;
    eb = erb ? ref_mem[ba] : '0;
    if (bv && bwe) ref_mem[ba] = bwd;

    @(negedge clk);
    a_valid = av; a_we = awe; a_addr = aa; a_wdata = awd;
    b_valid = bv; b_we = bwe; b_addr = ba; b_wdata = bwd;
    #1;
    chk(conf ? "R3 stall on same bank" : (av && bv ? "R2 no stall" : "R9 no stall"),
        32'(stall), 32'(conf));
    chk("R1 bank enables", 32'(bank_en), 32'(conf ? en0 : (en0 | en1)));
    if (av) chk("R1 A index", 32'(bank_idx[int'(aa[1:0])*IW +: IW]), 32'(aa[7:2]));
    if (bv && !conf) chk("R1 B index", 32'(bank_idx[int'(ba[1:0])*IW +: IW]), 32'(ba[7:2]));
    if (conf) begin
      @(negedge clk);
      if (junk) begin
        a_valid = 1'b1; a_we = 1'b1; a_addr = 8'h11; a_wdata = 16'hDEAD;
        b_valid = 1'b1; b_we = 1'b1; b_addr = 8'h22; b_wdata = 16'hBEEF;
      end
      #1;
      chk("R3 stall drops", 32'(stall), 32'd0);
      chk("R8 only held B bank", 32'(bank_en), 32'(en1));
      chk("R1 held B index", 32'(bank_idx[int'(ba[1:0])*IW +: IW]), 32'(ba[7:2]));
      chk("R6 no early A valid", 32'(a_rvalid), 32'd0);
      chk("R6 no early B valid", 32'(b_rvalid), 32'd0);
    end
    @(negedge clk);
    set_idle();
    #1;
    chk("R7 A rvalid", 32'(a_rvalid), 32'(era));
    chk("R7 B rvalid", 32'(b_rvalid), 32'(erb));
    if (era) chk(conf ? "R4 A data after conflict" : "R6 A data", 32'(a_rdata), 32'(ea));
    if (erb) chk(conf ? "R4 B data after conflict" : "R6 B data", 32'(b_rdata), 32'(eb));
    @(negedge clk);
    #1;
    chk("R7 A rvalid single pulse", 32'(a_rvalid), 32'd0);
    chk("R7 B rvalid single pulse", 32'(b_rvalid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int b = 0; b < NB; b++)
      for (int k = 0; k < DEPTH; k++) begin
        mem[b][k] = init_word(k * NB + b);
        ref_mem[k * NB + b] = init_word(k * NB + b);
      end
    set_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R10 stall after reset", 32'(stall), 32'd0);
    chk("R10 rvalid after reset", 32'({a_rvalid, b_rvalid}), 32'd0);
    chk("R10 banks idle after reset", 32'(bank_en), 32'd0);

    // Sweep all bank pairs and read/write mixes
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        for (int m = 0; m < 4; m++) begin
          logic [IW-1:0] ia, ib;
          ia = IW'(i * 7 + m * 3 + 1);
          ib = (i == j && m == 1) ? ia : IW'(j * 11 + m * 5 + 2);
          run_op(1'b1, m[0], {ia, 2'(i)}, DW'(i * 4096 + j * 256 + m * 16 + 5),
                 1'b1, m[1], {ib, 2'(j)}, DW'(i * 4096 + j * 256 + m * 16 + 2053),
                 (m == 2));
        end

    // R9: single port in each bank, read and write
    for (int b = 0; b < NB; b++) begin
      run_op(1'b1, 1'b0, AW'(b + 40), 16'h0, 1'b0, 1'b0, 8'h0, 16'h0, 1'b0);
      run_op(1'b0, 1'b0, 8'h0, 16'h0, 1'b1, 1'b1, AW'(b + 80), DW'(b + 16'h7700), 1'b0);
      run_op(1'b0, 1'b0, 8'h0, 16'h0, 1'b1, 1'b0, AW'(b + 80), 16'h0, 1'b0);
    end

    // R5: both write one address; B must win
    run_op(1'b1, 1'b1, 8'h9A, 16'h1111, 1'b1, 1'b1, 8'h9A, 16'h2222, 1'b0);
    run_op(1'b1, 1'b0, 8'h9A, 16'h0, 1'b0, 1'b0, 8'h0, 16'h0, 1'b0);
    chk("R5 B write wins", 32'(ref_mem[8'h9A]), 32'h2222);

    // R4: read A / write B same address, then write A / read B
    run_op(1'b1, 1'b0, 8'h5D, 16'h0, 1'b1, 1'b1, 8'h5D, 16'h3333, 1'b1);
    run_op(1'b1, 1'b1, 8'h6E, 16'h4444, 1'b1, 1'b0, 8'h6E, 16'h0, 1'b0);

    // R8: addresses written by junk inputs must hold their old contents
    run_op(1'b1, 1'b0, 8'h11, 16'h0, 1'b1, 1'b0, 8'h22, 16'h0, 1'b0);
    chk("R8 junk address A untouched", 32'(ref_mem[8'h11]), 32'(init_word(8'h11)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule